// File: doc/BRIEF.md
# Warp Instruction Issue Router

This block performs the issue step for a single warp scheduler. Each cycle it looks at the first few entries of the chosen warp's instruction buffer, oldest first. For each entry it picks the execution pipeline that should receive it: SP, INT, DP, SFU, tensor or memory. It also picks a free input slot in that pipeline's register set. Up to `MAX_ISSUE` instructions may leave in one cycle. The router stops at the first entry that cannot go, so order within the warp is kept.

The choice of pipeline depends on four things: the operation class, whether INT and DP units are present, and which pipeline slots are free. An optional mode forbids two consecutive issues in one cycle to the same unit type. A sub-core mode gives each scheduler a private slot in every pipeline register set, so this scheduler may only test and fill slot `SCHED_ID`.

Issue decisions are registered, so they appear one cycle after the inputs they were made from. Warp selection, the scoreboard and the execution units are outside this block.

Top module: `iss_router`

## Requirements
- R1: Operation code 6 (load, store, memory barrier, tensor load/store) goes only to the memory pipe (pipe bit 5), and only when that pipe has a usable free slot.
- R2: Operation code 1 (single-precision) goes to the SP pipe (bit 0). Codes 0 and 7 (generic ALU) go to the INT pipe (bit 1) when INT units are configured; if the INT pipe is full they do not fall back to SP. With no INT units, codes 0 and 7 go to the SP pipe.
- R3: Operation code 4 (double-precision) goes to the DP pipe (bit 2) when DP units are configured, and to the SFU pipe (bit 3) otherwise. Codes 2 (SFU) and 3 (combined ALU/SFU) go to the SFU pipe.
- R4: When the different-units mode is on, an instruction may not issue to the same pipe as the previous issue in the same cycle. Operation code 5 (tensor, pipe bit 4) is blocked only when the previous issue went to SP, so two tensor issues in one cycle are allowed.
- R5: Position k+1 issues only if position k issued in the same cycle. Nothing issues while the warp is waiting. A position whose buffer entry is not valid does not issue and stops the scan.
- R6: Outside sub-core mode, the lowest-numbered free slot of the target pipe is filled. A slot taken by one issue is unavailable to later issues in the same cycle, and a pipe with no free slot blocks the instruction.
- R7: In sub-core mode, only slot `SCHED_ID` of each pipe is tested and filled, and the scheduler id output equals `SCHED_ID` whenever position 0 issues.
- R8: Outputs are registered: they reflect the inputs of the previous cycle. Issue count = number of valid positions. All outputs are zero in reset.
- R9: For an issuing position, the pipe select and slot select are each one-hot. For a non-issuing position, both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_int_en_i | input | 1 | INT units are present |
| cfg_dp_en_i | input | 1 | DP units are present |
| cfg_diff_unit_i | input | 1 | Forbid back-to-back issue to the same unit type |
| cfg_sub_core_i | input | 1 | Sub-core mode: use own slot only |
| warp_wait_i | input | 1 | Selected warp is waiting; issue nothing |
| ibuf_vld_i | input | MAX_ISSUE | Valid bit per buffer head position |
| ibuf_op_i | input | 3*MAX_ISSUE | Operation code per position (3 bits each) |
| pipe_free_i | input | 6*NUM_SCHED | Free bit for each slot; bit p*NUM_SCHED+s = pipe p, slot s |
| iss_vld_o | output | MAX_ISSUE | Position issued |
| iss_pipe_o | output | 6*MAX_ISSUE | One-hot pipe select per position |
| iss_slot_o | output | NUM_SCHED*MAX_ISSUE | One-hot slot select per position |
| iss_sched_o | output | SID_W | Scheduler id attached to issued instructions |
| pop_cnt_o | output | CNT_W | Number of entries to pop from the buffer |

## Verification
The bench sweeps every pair of operation codes over all sixteen settings of the four configuration inputs, and crosses them with free-slot patterns. The patterns include full, empty, own-slot-only and all-but-own-slot.

Several faults are aimed at directly:
- A design that lets generic ALU work fall back to SP when the INT pipe is full shows an unexpected SP issue.
- A design that forgets the DP-to-SFU fallback leaves double-precision work stuck.
- A tensor rule that compares against the tensor type instead of SP would reject a second tensor issue, or accept tensor right after SP.
- A design that does not clear a slot taken earlier in the cycle puts both instructions in the same slot when only one is free.

Waiting warps and gaps in the buffer are mixed in. A scan that does not stop at the first blocked entry therefore shows as an out-of-order issue.

// File: rtl/iss_route_pkg.sv
package iss_route_pkg;
  localparam int NUM_PIPES = 6;
  localparam int OP_W      = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ALU     = 3'd0,
    OP_SP      = 3'd1,
    OP_SFU     = 3'd2,
    OP_ALU_SFU = 3'd3,
    OP_DP      = 3'd4,
    OP_TEN     = 3'd5,
    OP_MEM     = 3'd6,
    OP_MISC    = 3'd7
  } op_e;

  // pipe index doubles as the bit position in the one-hot select
  typedef enum logic [2:0] {
    P_SP   = 3'd0,
    P_INT  = 3'd1,
    P_DP   = 3'd2,
    P_SFU  = 3'd3,
    P_TEN  = 3'd4,
    P_MEM  = 3'd5,
    P_NONE = 3'd7
  } pipe_e;
endpackage

// File: rtl/iss_route_slot.sv
module iss_route_slot #(
  parameter int NUM_SCHED = 4,
  parameter int SCHED_ID  = 0
) (
  input  logic [NUM_SCHED-1:0] free_i,
  input  logic                 sub_core_i,
  output logic [NUM_SCHED-1:0] sel_o
);
  localparam logic [NUM_SCHED-1:0] OWN_MASK = NUM_SCHED'(1) << SCHED_ID;

  always_comb begin
    if (sub_core_i) sel_o = free_i & OWN_MASK;
    else            sel_o = free_i & (~free_i + NUM_SCHED'(1)); // lowest set bit
  end
endmodule

// File: rtl/iss_route_class.sv
module iss_route_class
  import iss_route_pkg::*;
(
  input  op_e                  op_i,
  input  logic                 int_en_i,
  input  logic                 dp_en_i,
  input  logic                 diff_i,
  input  logic [NUM_PIPES-1:0] pipe_ok_i,
  input  pipe_e                prev_i,
  output logic                 go_o,
  output pipe_e                tgt_o
);
  logic blocked;

  always_comb begin
    tgt_o   = P_SP;
    blocked = 1'b0;
    case (op_i)
      OP_MEM: begin
        tgt_o   = P_MEM;
        blocked = diff_i && (prev_i == P_MEM);
      end
      OP_SFU, OP_ALU_SFU: begin
        tgt_o   = P_SFU;
        blocked = diff_i && (prev_i == P_SFU);
      end
      OP_DP: begin
        tgt_o   = dp_en_i ? P_DP : P_SFU;
        blocked = diff_i && (prev_i == tgt_o);
      end
      OP_TEN: begin
        tgt_o   = P_TEN;
        blocked = diff_i && (prev_i == P_SP); // tensor is gated by SP history
      end
      OP_SP: begin
        tgt_o   = P_SP;
        blocked = diff_i && (prev_i == P_SP);
      end
      default: begin
        // generic ALU: INT when present, never falls back to SP
        tgt_o   = int_en_i ? P_INT : P_SP;
        blocked = diff_i && (prev_i == tgt_o);
      end
    endcase
    go_o = pipe_ok_i[tgt_o] && !blocked;
  end
endmodule

// File: rtl/iss_route_stage.sv
module iss_route_stage
  import iss_route_pkg::*;
#(
  parameter int NUM_SCHED = 4,
  parameter int SCHED_ID  = 0
) (
  input  logic                                exam_i,
  input  op_e                                 op_i,
  input  logic                                int_en_i,
  input  logic                                dp_en_i,
  input  logic                                diff_i,
  input  logic                                sub_core_i,
  input  logic [NUM_PIPES-1:0][NUM_SCHED-1:0] avail_i,
  input  pipe_e                               prev_i,
  output logic                                vld_o,
  output logic [NUM_PIPES-1:0]                pipe_o,
  output logic [NUM_SCHED-1:0]                slot_o,
  output logic [NUM_PIPES-1:0][NUM_SCHED-1:0] avail_o,
  output pipe_e                               prev_o
);
  logic [NUM_PIPES-1:0][NUM_SCHED-1:0] pick;
  logic [NUM_PIPES-1:0]                pipe_ok;
  logic                                go;
  pipe_e                               tgt;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pick
    iss_route_slot #(.NUM_SCHED(NUM_SCHED), .SCHED_ID(SCHED_ID)) u_slot (
      .free_i    (avail_i[p]),
      .sub_core_i(sub_core_i),
      .sel_o     (pick[p])
    );
    assign pipe_ok[p] = |pick[p];
  end

  iss_route_class u_class (
    .op_i     (op_i),
    .int_en_i (int_en_i),
    .dp_en_i  (dp_en_i),
    .diff_i   (diff_i),
    .pipe_ok_i(pipe_ok),
    .prev_i   (prev_i),
    .go_o     (go),
    .tgt_o    (tgt)
  );

  always_comb begin
    vld_o   = exam_i && go;
    pipe_o  = '0;
    slot_o  = '0;
    avail_o = avail_i;
    prev_o  = prev_i;
    if (vld_o) begin
      pipe_o[tgt]  = 1'b1;
      slot_o       = pick[tgt];
      avail_o[tgt] = avail_i[tgt] & ~pick[tgt];
      prev_o       = tgt;
    end
  end
endmodule

// File: rtl/iss_router.sv
module iss_router
  import iss_route_pkg::*;
#(
  parameter int MAX_ISSUE = 2,
  parameter int NUM_SCHED = 4,
  parameter int SCHED_ID  = 1,
  localparam int SID_W    = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
  localparam int CNT_W    = $clog2(MAX_ISSUE + 1)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_int_en_i,
  input  logic                           cfg_dp_en_i,
  input  logic                           cfg_diff_unit_i,
  input  logic                           cfg_sub_core_i,
  input  logic                           warp_wait_i,
  input  logic [MAX_ISSUE-1:0]           ibuf_vld_i,
  input  logic [MAX_ISSUE*OP_W-1:0]      ibuf_op_i,
  input  logic [NUM_PIPES*NUM_SCHED-1:0] pipe_free_i,
  output logic [MAX_ISSUE-1:0]           iss_vld_o,
  output logic [MAX_ISSUE*NUM_PIPES-1:0] iss_pipe_o,
  output logic [MAX_ISSUE*NUM_SCHED-1:0] iss_slot_o,
  output logic [SID_W-1:0]               iss_sched_o,
  output logic [CNT_W-1:0]               pop_cnt_o
);
  logic [MAX_ISSUE:0][NUM_PIPES-1:0][NUM_SCHED-1:0] av;
  pipe_e                                            prv [MAX_ISSUE+1];
  logic  [MAX_ISSUE-1:0]                            exam, vld;
  logic  [MAX_ISSUE-1:0][NUM_PIPES-1:0]             pipe_sel;
  logic  [MAX_ISSUE-1:0][NUM_SCHED-1:0]             slot_sel;
  logic  [CNT_W-1:0]                                cnt_d;

  assign av[0]  = pipe_free_i;
  assign prv[0] = P_NONE;

  for (genvar k = 0; k < MAX_ISSUE; k++) begin : g_pos
    if (k == 0) begin : g_head
      assign exam[k] = !warp_wait_i && ibuf_vld_i[k];
    end else begin : g_tail
      assign exam[k] = vld[k-1] && ibuf_vld_i[k]; // in-order: stop at first miss
    end

    iss_route_stage #(.NUM_SCHED(NUM_SCHED), .SCHED_ID(SCHED_ID)) u_stage (
      .exam_i    (exam[k]),
      .op_i      (op_e'(ibuf_op_i[k*OP_W +: OP_W])),
      .int_en_i  (cfg_int_en_i),
      .dp_en_i   (cfg_dp_en_i),
      .diff_i    (cfg_diff_unit_i),
      .sub_core_i(cfg_sub_core_i),
      .avail_i   (av[k]),
      .prev_i    (prv[k]),
      .vld_o     (vld[k]),
      .pipe_o    (pipe_sel[k]),
      .slot_o    (slot_sel[k]),
      .avail_o   (av[k+1]),
      .prev_o    (prv[k+1])
    );
  end

  always_comb begin
    cnt_d = '0;
    for (int k = 0; k < MAX_ISSUE; k++) cnt_d = cnt_d + CNT_W'(vld[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_vld_o   <= '0;
      iss_pipe_o  <= '0;
      iss_slot_o  <= '0;
      iss_sched_o <= '0;
      pop_cnt_o   <= '0;
    end else begin
      iss_vld_o   <= vld;
      iss_pipe_o  <= pipe_sel;
      iss_slot_o  <= slot_sel;
      iss_sched_o <= vld[0] ? SID_W'(SCHED_ID) : '0;
      pop_cnt_o   <= cnt_d;
    end
  end
endmodule

// File: rtl/iss_router_chk.sv
module iss_router_chk #(
  parameter int MAX_ISSUE = 2,
  parameter int NUM_SCHED = 4,
  parameter int SCHED_ID  = 1,
  localparam int SID_W    = (NUM_SCHED > 1) ? $clog2(NUM_SCHED) : 1,
  localparam int CNT_W    = $clog2(MAX_ISSUE + 1),
  localparam int NP       = 6,
  localparam int OW       = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     cfg_int_en_i,
  input logic                     cfg_dp_en_i,
  input logic                     cfg_diff_unit_i,
  input logic                     cfg_sub_core_i,
  input logic                     warp_wait_i,
  input logic [MAX_ISSUE-1:0]     ibuf_vld_i,
  input logic [MAX_ISSUE*OW-1:0]  ibuf_op_i,
  input logic [NP*NUM_SCHED-1:0]  pipe_free_i,
  input logic [MAX_ISSUE-1:0]     iss_vld_o,
  input logic [MAX_ISSUE*NP-1:0]  iss_pipe_o,
  input logic [MAX_ISSUE*NUM_SCHED-1:0] iss_slot_o,
  input logic [SID_W-1:0]         iss_sched_o,
  input logic [CNT_W-1:0]         pop_cnt_o
);
  logic [MAX_ISSUE-1:0][NP*NUM_SCHED-1:0] used;
  logic overlap;

  always_comb begin
    for (int k = 0; k < MAX_ISSUE; k++)
      for (int p = 0; p < NP; p++)
        for (int s = 0; s < NUM_SCHED; s++)
          used[k][p*NUM_SCHED+s] = iss_pipe_o[k*NP+p] & iss_slot_o[k*NUM_SCHED+s];
    overlap = 1'b0;
    for (int a = 0; a < MAX_ISSUE; a++)
      for (int b = a + 1; b < MAX_ISSUE; b++)
        if ((used[a] & used[b]) != '0) overlap = 1'b1;
  end

  p_no_double_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni) !overlap);
  p_pop_count_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_cnt_o == CNT_W'($countones(iss_vld_o)));
  p_wait_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(warp_wait_i) |-> iss_vld_o == '0);
  p_head_invalid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ibuf_vld_i[0]) |-> iss_vld_o == '0);
  p_sched_tag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_vld_o[0] |-> iss_sched_o == SID_W'(SCHED_ID));

  for (genvar k = 0; k < MAX_ISSUE; k++) begin : g_k
    p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_vld_o[k] |-> $onehot(iss_pipe_o[k*NP +: NP]) && $onehot(iss_slot_o[k*NUM_SCHED +: NUM_SCHED]));
    p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !iss_vld_o[k] |-> iss_pipe_o[k*NP +: NP] == '0 && iss_slot_o[k*NUM_SCHED +: NUM_SCHED] == '0);
    p_slot_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (used[k] & ~$past(pipe_free_i)) == '0);
    p_mem_only_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_vld_o[k] |-> (iss_pipe_o[k*NP+5] == ($past(ibuf_op_i[k*OW +: OW]) == 3'd6)));
    p_alu_int_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_vld_o[k] && $past(cfg_int_en_i) && ($past(ibuf_op_i[k*OW +: OW]) == 3'd0) |-> iss_pipe_o[k*NP+1]);
    p_dp_route_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_vld_o[k] && ($past(ibuf_op_i[k*OW +: OW]) == 3'd4) |->
        ($past(cfg_dp_en_i) ? iss_pipe_o[k*NP+2] : iss_pipe_o[k*NP+3]));
    p_own_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_vld_o[k] && $past(cfg_sub_core_i) |-> iss_slot_o[k*NUM_SCHED +: NUM_SCHED] == NUM_SCHED'(1) << SCHED_ID);
    if (k > 0) begin : g_pair
      p_in_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_o[k] |-> iss_vld_o[k-1]);
      p_diff_unit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_o[k] && $past(cfg_diff_unit_i) |->
          ((iss_pipe_o[k*NP +: NP] != iss_pipe_o[(k-1)*NP +: NP]) || iss_pipe_o[k*NP+4]) &&
          !(iss_pipe_o[(k-1)*NP] && iss_pipe_o[k*NP+4]));
    end
  end
endmodule

bind iss_router iss_router_chk #(
  .MAX_ISSUE(MAX_ISSUE), .NUM_SCHED(NUM_SCHED), .SCHED_ID(SCHED_ID)
) u_chk (.*);

// File: tb/sim_iss_router.sv
`timescale 1ns/1ps
module sim_iss_router;
  localparam int MI = 2, NS = 4, SID = 1, NP = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_int_en_i = 0, cfg_dp_en_i = 0, cfg_diff_unit_i = 0, cfg_sub_core_i = 0;
  logic warp_wait_i = 0;
  logic [MI-1:0]    ibuf_vld_i = '0;
  logic [MI*3-1:0]  ibuf_op_i = '0;
  logic [NP*NS-1:0] pipe_free_i = '0;
  logic [MI-1:0]    iss_vld_o;
  logic [MI*NP-1:0] iss_pipe_o;
  logic [MI*NS-1:0] iss_slot_o;
  logic [1:0]       iss_sched_o;
  logic [1:0]       pop_cnt_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  iss_router #(.MAX_ISSUE(MI), .NUM_SCHED(NS), .SCHED_ID(SID)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_int_en_i(cfg_int_en_i), .cfg_dp_en_i(cfg_dp_en_i),
    .cfg_diff_unit_i(cfg_diff_unit_i), .cfg_sub_core_i(cfg_sub_core_i),
    .warp_wait_i(warp_wait_i), .ibuf_vld_i(ibuf_vld_i), .ibuf_op_i(ibuf_op_i),
    .pipe_free_i(pipe_free_i), .iss_vld_o(iss_vld_o), .iss_pipe_o(iss_pipe_o),
    .iss_slot_o(iss_slot_o), .iss_sched_o(iss_sched_o), .pop_cnt_o(pop_cnt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd6:                   return "R1";
      3'd2, 3'd3, 3'd4:       return "R3";
      3'd5:                   return "R4";
      default:                return "R2";
    endcase
  endfunction

  // expected result from the requirements; cfg = {sub, diff, dp, int}
  task automatic model(input logic [3:0] cfg, input logic [5:0] ops, input logic [23:0] fr,
                       input logic w, input logic [1:0] v,
                       output logic [1:0] ev, output logic [11:0] ep, output logic [7:0] es);
    logic [23:0] av;
    int prev, tgt, s;
    bit run, ok;
    logic [2:0] op;
    av = fr; prev = -1; run = !w; ev = '0; ep = '0; es = '0;
    for (int k = 0; k < 2; k++) begin
      op = ops[k*3 +: 3];
      if (run && v[k]) begin
        ok = 1;
        case (op)
          3'd6: begin tgt = 5; if (cfg[2] && prev == 5) ok = 0; end
          3'd2, 3'd3: begin tgt = 3; if (cfg[2] && prev == 3) ok = 0; end
          3'd4: begin tgt = cfg[1] ? 2 : 3; if (cfg[2] && prev == tgt) ok = 0; end
          3'd5: begin tgt = 4; if (cfg[2] && prev == 0) ok = 0; end
          3'd1: begin tgt = 0; if (cfg[2] && prev == 0) ok = 0; end
          default: begin tgt = cfg[0] ? 1 : 0; if (cfg[2] && prev == tgt) ok = 0; end
        endcase
        s = -1;
        if (cfg[3]) begin
          if (av[tgt*4+SID]) s = SID;
        end else begin
          for (int j = 3; j >= 0; j--) if (av[tgt*4+j]) s = j;
        end
        if (s < 0) ok = 0;
        if (ok) begin
          ev[k] = 1'b1; ep[k*6+tgt] = 1'b1; es[k*4+s] = 1'b1;
          av[tgt*4+s] = 1'b0; prev = tgt;
        end else run = 0;
      end else run = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [1:0] ev; logic [11:0] ep; logic [7:0] es;
    logic [23:0] fr; logic [31:0] h;
    logic w; logic [1:0] v;
    int n;
    string tg;
    pipe_free_i = '1; ibuf_vld_i = '1; ibuf_op_i = 6'o11;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset vld", 32'(iss_vld_o), 0);
    chk("R8 reset pipe", 32'(iss_pipe_o), 0);
    chk("R8 reset slot", 32'(iss_slot_o), 0);
    chk("R8 reset cnt", 32'(pop_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    n = 0;
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < 8; a++)
        for (int b = 0; b < 8; b++)
          for (int f = 0; f < 6; f++) begin
            h = (n * 32'h9E3779B1) ^ (n >> 3);
            case (f)
              0: fr = 24'hFFFFFF;
              1: fr = 24'h000000;
              2: fr = 24'h222222;
              3: fr = 24'hDDDDDD;
              4: fr = h[27:4];
              default: fr = ~h[31:8];
            endcase
            w = (n % 17 == 5);
            v = (n % 23 == 7) ? 2'b10 : (n % 19 == 3) ? 2'b01 : 2'b11;
            {cfg_sub_core_i, cfg_diff_unit_i, cfg_dp_en_i, cfg_int_en_i} = 4'(c);
            ibuf_op_i = {3'(b), 3'(a)};
            pipe_free_i = fr; warp_wait_i = w; ibuf_vld_i = v;
            model(4'(c), {3'(b), 3'(a)}, fr, w, v, ev, ep, es);
            @(negedge clk);
            for (int k = 0; k < 2; k++) begin
              if (w || !v[0] || (k == 1 && !v[1])) tg = "R5";
              else if (k == 1 && c[2]) tg = "R4";
              else tg = op_tag(k == 0 ? 3'(a) : 3'(b));
              chk({tg, " issue"}, 32'(iss_vld_o[k]), 32'(ev[k]));
              chk({tg, " pipe"}, 32'(iss_pipe_o[k*6 +: 6]), 32'(ep[k*6 +: 6]));
              chk(c[3] ? "R7 slot" : "R6 slot", 32'(iss_slot_o[k*4 +: 4]), 32'(es[k*4 +: 4]));
              chk("R9 onehot", 32'($countones(iss_pipe_o[k*6 +: 6]) <= 1), 1);
            end
            chk("R8 pop count", 32'(pop_cnt_o), 32'(ev[0]) + 32'(ev[1]));
            if (ev[0]) chk("R7 sched id", 32'(iss_sched_o), SID);
            n++;
          end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule